// File: doc/BRIEF.md
# Configurable UART transceiver with error flags

A full-duplex asynchronous serial transceiver that runs from the peripheral clock. A bit-rate generator produces a sampling tick at 16 times the bit rate. A two-bit prescale `n` and an eight-bit divisor `N` set the rate. The bit time is 32·4^n·(N+1) clock cycles, so the bit rate is PCLK / (64·2^(2n−1)·(N+1)). With a 50 MHz clock, n=0 and N=40 give about 38.1 kbit/s. Software would pick that setting for a nominal 38.4 kbit/s and accept an error of about −0.75 %.

The frame shape is set through configuration inputs and may change between characters. The data field is 7, 8 or 9 bits and goes LSB first or MSB first. An even or odd parity bit is optional, and the frame ends with one or two stop bits.

The transmitter has a one-entry holding register that feeds a shift register. The receiver confirms each start bit at mid-bit and samples every later bit at mid-bit. It places each character in a receive register. Sticky status flags report parity errors, framing errors and overruns. A transmit-end flag and two single-cycle interrupt pulses let a driver pace both directions.

Top module: `uart_core`

## Requirements
- R1: The serial output is high while idle or while the transmitter is disabled. Each frame sends a low start bit, then the data bits, then the optional parity bit, then one or two high stop bits.
- R2: When `cfg_msb_first_i` is 0, data goes out and comes in least significant bit first. When it is 1, the highest bit of the selected length goes first. The length code in `cfg_len_i` is 0 or 3 for 8 bits, 1 for 7 bits and 2 for 9 bits.
- R3: With `cfg_par_en_i` high, a parity bit follows the data. It makes the count of ones over data and parity even when `cfg_par_odd_i` is 0, and odd when it is 1.
- R4: Every transmitted bit, the start bit included, lasts exactly 32·4^n·(N+1) clock cycles, where n is `cfg_prescale_i` and N is `cfg_div_i`.
- R5: A received character appears on `rx_data_o` with its unused upper bits at zero, and `rx_valid_o` rises with it. A one-cycle `rx_rd_i` clears `rx_valid_o`.
- R6: `per_o` sets when parity is enabled and the received parity does not match the selected mode. `fer_o` sets when the first stop bit is sampled low.
- R7: A character that completes while `rx_valid_o` or `orer_o` is set raises `orer_o` and is dropped, so `rx_data_o` keeps the older character. The flags stay set until their bit of `err_clr_i` is pulsed: bit 0 clears parity, bit 1 clears framing, bit 2 clears overrun.
- R8: `tend_o` is 1 after reset and whenever the transmitter is disabled. An accepted write clears it. It sets again when the last stop bit ends with no character waiting.
- R9: `irq_tx_o` pulses for one cycle each time the holding register passes a character to the shifter. `irq_rx_o` pulses for one cycle for each character stored.
- R10: A low pulse on `rxd_i` that is high again at the 8th sampling tick after its falling edge is discarded, with no character and no flag.
- R11: With `cfg_stop2_i` set, back-to-back frames keep the line high for two full bit times between characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_len_i | input | 2 | Data length code (0/3: 8, 1: 7, 2: 9 bits) |
| cfg_msb_first_i | input | 1 | 1 selects MSB-first bit order |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | 1 selects odd parity, 0 even |
| cfg_stop2_i | input | 1 | 1 selects two stop bits |
| cfg_prescale_i | input | 2 | Prescale exponent n (clock / 2·4^n) |
| cfg_div_i | input | 8 | Divisor N (further divide by N+1) |
| tx_en_i | input | 1 | Transmitter enable |
| rx_en_i | input | 1 | Receiver enable |
| tx_wr_i | input | 1 | Write strobe for the transmit holding register |
| tx_data_i | input | 9 | Character to transmit |
| rx_rd_i | input | 1 | Read strobe that releases the receive register |
| err_clr_i | input | 3 | Flag clear strobes: [0] parity, [1] framing, [2] overrun |
| rxd_i | input | 1 | Serial input |
| txd_o | output | 1 | Serial output |
| rx_data_o | output | 9 | Last stored received character |
| rx_valid_o | output | 1 | Receive register holds an unread character |
| tend_o | output | 1 | Transmitter idle with nothing pending |
| per_o | output | 1 | Parity error flag |
| fer_o | output | 1 | Framing error flag |
| orer_o | output | 1 | Overrun flag |
| irq_rx_o | output | 1 | Character-received pulse |
| irq_tx_o | output | 1 | Holding-register-free pulse |

## Verification
The assertions assume that the configuration inputs do not change while a character is in flight. They also assume that a read strobe never falls in the cycle where a character completes, so that the flag and interrupt timing stays unambiguous. The stimulus changes the frame shape and the rate only after the transmit-end flag is set and the receive line has returned to idle. It drives received frames with bit times computed from the same prescale and divisor settings. It pulses read and clear strobes only between frames.

// File: rtl/uart_pkg.sv
package uart_pkg;
  parameter int MAX_DATA = 9;
  parameter int FRAME_W  = MAX_DATA + 4;  // start + data + parity + 2 stop
  parameter int OVS      = 16;

  typedef struct packed {
    logic [1:0] len;
    logic       msb_first;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
  } frame_cfg_t;

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_e;

  function automatic logic [3:0] data_bits(input logic [1:0] len);
    case (len)
      2'd1:    data_bits = 4'd7;
      2'd2:    data_bits = 4'd9;
      default: data_bits = 4'd8;
    endcase
  endfunction

  // reversal within nb bits; its own inverse, so rx and tx share it
  function automatic logic [MAX_DATA-1:0] order_bits(input logic [MAX_DATA-1:0] d,
                                                     input logic [3:0] nb,
                                                     input logic msb);
    logic [MAX_DATA-1:0] o;
    logic [3:0] j;
    o = '0;
    for (int i = 0; i < MAX_DATA; i++) begin
      j = nb - 4'd1 - 4'(i);
      if (4'(i) < nb) o[i] = msb ? d[j] : d[i];
    end
    return o;
  endfunction

  function automatic logic parity_of(input logic [MAX_DATA-1:0] d, input logic [3:0] nb);
    logic p;
    p = 1'b0;
    for (int i = 0; i < MAX_DATA; i++)
      if (4'(i) < nb) p ^= d[i];
    return p;
  endfunction
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int PRE_W = 2,
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] prescale_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int PCNT_W = 2 * ((1 << PRE_W) - 1) + 1;

  logic [PCNT_W-1:0] pre_q, pre_lim;
  logic [DIV_W-1:0]  div_q;

  // prescale divides by 2*4^n
  always_comb pre_lim = PCNT_W'((32'd2 << {prescale_i, 1'b0}) - 32'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      div_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (pre_q >= pre_lim) begin
        pre_q <= '0;
        if (div_q >= div_i) begin
          div_q  <= '0;
          tick_o <= 1'b1;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                en_i,
  input  frame_cfg_t          cfg_i,
  input  logic                wr_i,
  input  logic [MAX_DATA-1:0] data_i,
  output logic                txd_o,
  output logic                tend_o,
  output logic                rdy_irq_o
);
  localparam int CNT_W = $clog2(OVS);

  logic [MAX_DATA-1:0] tdr_q;
  logic                tdr_full_q, busy_q;
  logic [FRAME_W-1:0]  frame_q, frame_nxt;
  logic [3:0]          left_q, total_nxt;
  logic [CNT_W-1:0]    cnt_q;
  logic [3:0]          nb;
  logic [FRAME_W-1:0]  ordx;
  logic                par_bit;

  always_comb begin
    nb        = data_bits(cfg_i.len);
    ordx      = FRAME_W'(order_bits(tdr_q, nb, cfg_i.msb_first));
    par_bit   = parity_of(tdr_q, nb) ^ cfg_i.par_odd;
    frame_nxt = '1;
    frame_nxt[0] = 1'b0;
    for (int j = 1; j < FRAME_W; j++) begin
      if (4'(j) <= nb)                             frame_nxt[j] = ordx[j-1];
      else if (cfg_i.par_en && 4'(j) == nb + 4'd1) frame_nxt[j] = par_bit;
    end
    total_nxt = 4'd2 + nb + {3'd0, cfg_i.par_en} + {3'd0, cfg_i.stop2};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdr_q      <= '0;
      tdr_full_q <= 1'b0;
      busy_q     <= 1'b0;
      frame_q    <= '1;
      left_q     <= '0;
      cnt_q      <= '0;
      tend_o     <= 1'b1;
      rdy_irq_o  <= 1'b0;
    end else begin
      rdy_irq_o <= 1'b0;
      if (!en_i) begin
        tdr_full_q <= 1'b0;
        busy_q     <= 1'b0;
        frame_q    <= '1;
        cnt_q      <= '0;
        tend_o     <= 1'b1;
      end else begin
        if (tick_i) begin
          if (!busy_q || (cnt_q == CNT_W'(OVS - 1) && left_q == 4'd1)) begin
            cnt_q <= '0;
            if (tdr_full_q) begin
              frame_q    <= frame_nxt;
              left_q     <= total_nxt;
              busy_q     <= 1'b1;
              tdr_full_q <= 1'b0;
              rdy_irq_o  <= 1'b1;
            end else if (busy_q) begin
              busy_q <= 1'b0;
              tend_o <= 1'b1;
            end
          end else if (cnt_q == CNT_W'(OVS - 1)) begin
            cnt_q   <= '0;
            frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
            left_q  <= left_q - 4'd1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        // after tick handling so an accepted write wins over tend set
        if (wr_i && !tdr_full_q) begin
          tdr_q      <= data_i;
          tdr_full_q <= 1'b1;
          tend_o     <= 1'b0;
        end
      end
    end
  end

  assign txd_o = busy_q ? frame_q[0] : 1'b1;
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                en_i,
  input  frame_cfg_t          cfg_i,
  input  logic                rxd_i,
  input  logic                rd_i,
  input  logic [2:0]          clr_i,
  output logic [MAX_DATA-1:0] data_o,
  output logic                valid_o,
  output logic                per_o,
  output logic                fer_o,
  output logic                orer_o,
  output logic                full_irq_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] MID = CNT_W'(OVS / 2 - 1);

  rx_state_e           state_q;
  frame_cfg_t          cfg_q;
  logic [2:0]          sync_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [3:0]          idx_q, nb;
  logic [MAX_DATA-1:0] raw_q, data_w;
  logic                par_q, line, fall, perr;

  assign line = sync_q[1];
  assign fall = sync_q[2] & ~sync_q[1];

  always_comb begin
    nb     = data_bits(cfg_q.len);
    data_w = order_bits(raw_q, nb, cfg_q.msb_first);
    perr   = cfg_q.par_en && ((parity_of(raw_q, nb) ^ par_q) != cfg_q.par_odd);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RX_IDLE;
      cfg_q      <= '0;
      sync_q     <= '1;
      cnt_q      <= '0;
      idx_q      <= '0;
      raw_q      <= '0;
      par_q      <= 1'b0;
      data_o     <= '0;
      valid_o    <= 1'b0;
      per_o      <= 1'b0;
      fer_o      <= 1'b0;
      orer_o     <= 1'b0;
      full_irq_o <= 1'b0;
    end else begin
      full_irq_o <= 1'b0;
      sync_q     <= {sync_q[1:0], rxd_i};
      if (rd_i)     valid_o <= 1'b0;
      if (clr_i[0]) per_o   <= 1'b0;
      if (clr_i[1]) fer_o   <= 1'b0;
      if (clr_i[2]) orer_o  <= 1'b0;
      if (!en_i) begin
        state_q <= RX_IDLE;
      end else if (state_q == RX_IDLE) begin
        if (fall) begin
          state_q <= RX_START;
          cnt_q   <= '0;
          cfg_q   <= cfg_i;
        end
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == MID) begin
          unique case (state_q)
            RX_START: begin
              if (line) state_q <= RX_IDLE;  // glitch, not a start bit
              else begin
                state_q <= RX_DATA;
                idx_q   <= '0;
                raw_q   <= '0;
              end
            end
            RX_DATA: begin
              raw_q[idx_q] <= line;
              if (idx_q == nb - 4'd1) state_q <= cfg_q.par_en ? RX_PAR : RX_STOP;
              else idx_q <= idx_q + 4'd1;
            end
            RX_PAR: begin
              par_q   <= line;
              state_q <= RX_STOP;
            end
            RX_STOP: begin
              state_q <= RX_IDLE;
              if (valid_o || orer_o) begin
                orer_o <= 1'b1;
              end else begin
                data_o     <= data_w;
                valid_o    <= 1'b1;
                full_irq_o <= 1'b1;
                if (perr)  per_o <= 1'b1;
                if (!line) fer_o <= 1'b1;
              end
            end
            default: state_q <= RX_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/uart_core.sv
module uart_core
  import uart_pkg::*;
#(
  parameter int PRE_W = 2,
  parameter int DIV_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          cfg_len_i,
  input  logic                cfg_msb_first_i,
  input  logic                cfg_par_en_i,
  input  logic                cfg_par_odd_i,
  input  logic                cfg_stop2_i,
  input  logic [PRE_W-1:0]    cfg_prescale_i,
  input  logic [DIV_W-1:0]    cfg_div_i,
  input  logic                tx_en_i,
  input  logic                rx_en_i,
  input  logic                tx_wr_i,
  input  logic [MAX_DATA-1:0] tx_data_i,
  input  logic                rx_rd_i,
  input  logic [2:0]          err_clr_i,
  input  logic                rxd_i,
  output logic                txd_o,
  output logic [MAX_DATA-1:0] rx_data_o,
  output logic                rx_valid_o,
  output logic                tend_o,
  output logic                per_o,
  output logic                fer_o,
  output logic                orer_o,
  output logic                irq_rx_o,
  output logic                irq_tx_o
);
  frame_cfg_t cfg;
  logic       tick;

  assign cfg.len       = cfg_len_i;
  assign cfg.msb_first = cfg_msb_first_i;
  assign cfg.par_en    = cfg_par_en_i;
  assign cfg.par_odd   = cfg_par_odd_i;
  assign cfg.stop2     = cfg_stop2_i;

  uart_baud_gen #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_baud (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .prescale_i (cfg_prescale_i),
    .div_i      (cfg_div_i),
    .tick_o     (tick)
  );

  uart_tx u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .en_i      (tx_en_i),
    .cfg_i     (cfg),
    .wr_i      (tx_wr_i),
    .data_i    (tx_data_i),
    .txd_o     (txd_o),
    .tend_o    (tend_o),
    .rdy_irq_o (irq_tx_o)
  );

  uart_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .en_i       (rx_en_i),
    .cfg_i      (cfg),
    .rxd_i      (rxd_i),
    .rd_i       (rx_rd_i),
    .clr_i      (err_clr_i),
    .data_o     (rx_data_o),
    .valid_o    (rx_valid_o),
    .per_o      (per_o),
    .fer_o      (fer_o),
    .orer_o     (orer_o),
    .full_irq_o (irq_rx_o)
  );
endmodule

// File: rtl/uart_core_chk.sv
module uart_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_en_i,
  input logic [2:0] err_clr_i,
  input logic       txd_o,
  input logic [8:0] rx_data_o,
  input logic       rx_valid_o,
  input logic       tend_o,
  input logic       per_o,
  input logic       fer_o,
  input logic       orer_o,
  input logic       irq_rx_o,
  input logic       irq_tx_o
);
  AST_TXD_HIGH_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> txd_o);  // R1
  AST_TEND_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> tend_o);  // R8
  AST_RX_IRQ_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rx_o |-> rx_valid_o);  // R5
  AST_PER_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_o && !err_clr_i[0]) |=> per_o);  // R6
  AST_FER_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fer_o && !err_clr_i[1]) |=> fer_o);  // R6
  AST_ORER_HOLD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    orer_o |=> $stable(rx_data_o));  // R7
  AST_ORER_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (orer_o && !err_clr_i[2]) |=> orer_o);  // R7
  AST_RX_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rx_o |=> !irq_rx_o);  // R9
  AST_TX_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_tx_o |=> !irq_tx_o);  // R9
endmodule

bind uart_core uart_core_chk u_chk (.*);

// File: tb/sim_uart_core.sv
module sim_uart_core;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] len = 2'd0, pre = 2'd0;
  logic msb = 0, pe = 0, po = 0, st2 = 0;
  logic [7:0] dv = 8'd0;
  logic tx_en = 0, rx_en = 0, tx_wr = 0, rx_rd = 0, rxd = 1;
  logic [8:0] tx_data = '0;
  logic [2:0] err_clr = '0;
  logic txd, rx_valid, tend, per, fer, orer, irq_rx, irq_tx;
  logic [8:0] rx_data;

  uart_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_len_i(len), .cfg_msb_first_i(msb),
    .cfg_par_en_i(pe), .cfg_par_odd_i(po), .cfg_stop2_i(st2),
    .cfg_prescale_i(pre), .cfg_div_i(dv), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data), .rx_rd_i(rx_rd), .err_clr_i(err_clr),
    .rxd_i(rxd), .txd_o(txd), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .tend_o(tend), .per_o(per), .fer_o(fer), .orer_o(orer),
    .irq_rx_o(irq_rx), .irq_tx_o(irq_tx)
  );

  int n_chk = 0, n_fail = 0;
  int tx_wr_cnt = 0, tx_irq_cnt = 0, rx_irq_cnt = 0;

  typedef struct { logic [12:0] f; int n; string req; } tx_exp_t;
  typedef struct { logic [8:0] d; bit per; bit fer; string req; } rx_exp_t;
  tx_exp_t txq[$];
  rx_exp_t rxq[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bit_period();
    return 32 * (1 << (2 * pre)) * (int'(dv) + 1);
  endfunction

  function automatic int nbits();
    return (len == 2'd1) ? 7 : (len == 2'd2) ? 9 : 8;
  endfunction

  function automatic logic [12:0] build(input logic [8:0] d, input bit bad_par,
                                        input bit stop_low, output int n);
    logic [12:0] f;
    logic b, p;
    int pos, nb;
    nb = nbits();
    f = '1;
    f[0] = 1'b0;
    p = 1'b0;
    pos = 1;
    for (int k = 0; k < nb; k++) begin
      b = msb ? d[nb-1-k] : d[k];
      f[pos] = b;
      p ^= b;
      pos++;
    end
    if (pe) begin
      f[pos] = p ^ po ^ bad_par;
      pos++;
    end
    f[pos] = ~stop_low;
    pos++;
    if (st2) pos++;
    n = pos;
    return f;
  endfunction

  always @(negedge clk) if (rst_n && irq_tx) tx_irq_cnt++;

  task automatic tx_send(input logic [8:0] d, input string req);
    tx_exp_t e;
    e.f = build(d, 1'b0, 1'b0, e.n);
    e.req = req;
    txq.push_back(e);
    while (tx_wr_cnt != tx_irq_cnt) @(negedge clk);
    tx_wr = 1'b1;
    tx_data = d;
    tx_wr_cnt++;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic wait_tx_idle();
    while (txq.size() != 0 || !tend) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // tx monitor: decode each frame at mid-bit, compare with the queue
  initial begin
    logic [12:0] got;
    tx_exp_t e;
    int p;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        p = bit_period();
        if (txq.size() == 0) begin
          chk(0, "R1 unexpected frame", 0, 1);
          e.n = 2;
          e.f = '1;
        end else e = txq.pop_front();
        got = '1;
        repeat (p / 2) @(negedge clk);
        got[0] = txd;
        for (int i = 1; i < e.n; i++) begin
          repeat (p) @(negedge clk);
          got[i] = txd;
        end
        for (int i = e.n; i < 13; i++) got[i] = 1'b1;
        chk(got == e.f, e.req, 32'(got), 32'(e.f));
      end
    end
  end

  // rx monitor: pop expected character on every receive pulse
  initial begin
    rx_exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && irq_rx) begin
        rx_irq_cnt++;
        if (rxq.size() == 0) chk(0, "R9 unexpected rx pulse", 1, 0);
        else begin
          e = rxq.pop_front();
          chk(rx_data == e.d, e.req, 32'(rx_data), 32'(e.d));
          chk(per == e.per, "R6 parity flag", 32'(per), 32'(e.per));
          chk(fer == e.fer, "R6 framing flag", 32'(fer), 32'(e.fer));
        end
      end
    end
  end

  task automatic rx_send(input logic [8:0] d, input bit bad_par, input bit stop_low,
                         input bit expect_chr, input string req);
    rx_exp_t e;
    logic [12:0] f;
    int n, p;
    f = build(d, bad_par, stop_low, n);
    p = bit_period();
    if (expect_chr) begin
      e.d = d & ((9'd1 << nbits()) - 9'd1);
      e.per = bad_par;
      e.fer = stop_low;
      e.req = req;
      rxq.push_back(e);
    end
    for (int i = 0; i < n; i++) begin
      rxd = f[i];
      repeat (p) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (p) @(negedge clk);
  endtask

  task automatic rd_pulse();
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic clr_pulse(input logic [2:0] b);
    err_clr = b;
    @(negedge clk);
    err_clr = '0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int cnt, irq0;
    repeat (5) @(negedge clk);
    // reset state
    chk(txd == 1'b1, "R1 idle line", 32'(txd), 1);
    chk(tend == 1'b1, "R8 tend at reset", 32'(tend), 1);
    chk({rx_valid, per, fer, orer} == 4'b0, "R5 rx flags at reset", 32'({rx_valid, per, fer, orer}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    tx_en = 1'b1;
    rx_en = 1'b1;
    @(negedge clk);

    // 8N1 LSB first, back to back
    tx_send(9'h0A5, "R1 8N1 frame");
    chk(tend == 1'b0, "R8 tend cleared by write", 32'(tend), 0);
    tx_send(9'h03C, "R1 8N1 second frame");
    wait_tx_idle();
    chk(tend == 1'b1, "R8 tend after last stop", 32'(tend), 1);

    // 7 bits, MSB first, even parity, two stops
    len = 2'd1; msb = 1; pe = 1; po = 0; st2 = 1;
    tx_send(9'h05B, "R2 R3 R11 7E2 msb first");
    tx_send(9'h012, "R11 second 7E2 frame");
    wait_tx_idle();

    // 9 bits, odd parity, LSB first
    len = 2'd2; msb = 0; pe = 1; po = 1; st2 = 0;
    tx_send(9'h1A7, "R3 9O1 frame");
    wait_tx_idle();

    // bit time with prescale 1, divisor 2
    len = 2'd0; pe = 0; pre = 2'd1; dv = 8'd2;
    fork
      tx_send(9'h001, "R4 slow frame");
      begin
        while (txd !== 1'b0) @(negedge clk);
        cnt = 0;
        while (txd === 1'b0) begin
          cnt++;
          @(negedge clk);
        end
        chk(cnt == 384, "R4 start bit length", 32'(cnt), 384);
      end
    join
    wait_tx_idle();
    pre = 2'd0; dv = 8'd0;
    chk(tx_irq_cnt == tx_wr_cnt, "R9 one tx pulse per write", 32'(tx_irq_cnt), 32'(tx_wr_cnt));

    // disabled transmitter
    tx_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(txd == 1'b1 && tend == 1'b1, "R8 disabled tx", 32'({txd, tend}), 3);
    tx_en = 1'b1;

    // receive 8N1
    rx_send(9'h06E, 0, 0, 1, "R5 rx 8N1");
    chk(rx_valid == 1'b1, "R5 valid set", 32'(rx_valid), 1);
    rd_pulse();
    chk(rx_valid == 1'b0, "R5 read clears valid", 32'(rx_valid), 0);

    // receive 7 bits msb first, even parity
    len = 2'd1; msb = 1; pe = 1; po = 0;
    rx_send(9'h04D, 0, 0, 1, "R2 rx msb first");
    rd_pulse();

    // parity error
    rx_send(9'h02B, 1, 0, 1, "R6 rx parity error data");
    rd_pulse();
    clr_pulse(3'b001);
    chk(per == 1'b0, "R7 parity clear", 32'(per), 0);

    // framing error
    len = 2'd0; msb = 0; pe = 0;
    rx_send(9'h081, 0, 1, 1, "R6 rx framing error data");
    rd_pulse();
    clr_pulse(3'b010);
    chk(fer == 1'b0, "R7 framing clear", 32'(fer), 0);

    // false start
    irq0 = rx_irq_cnt;
    rxd = 1'b0;
    repeat (bit_period() / 4) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * bit_period()) @(negedge clk);
    chk(rx_valid == 1'b0 && rx_irq_cnt == irq0, "R10 glitch ignored", 32'(rx_valid), 0);
    chk({per, fer, orer} == 3'b0, "R10 no flags", 32'({per, fer, orer}), 0);

    // overrun
    rx_send(9'h011, 0, 0, 1, "R7 first char");
    rx_send(9'h022, 0, 0, 0, "R7");
    chk(orer == 1'b1, "R7 overrun set", 32'(orer), 1);
    chk(rx_data == 9'h011, "R7 older char kept", 32'(rx_data), 32'h11);
    rd_pulse();
    rx_send(9'h033, 0, 0, 0, "R7");
    chk(rx_data == 9'h011 && rx_valid == 1'b0, "R7 blocked while overrun", 32'(rx_data), 32'h11);
    clr_pulse(3'b100);
    chk(orer == 1'b0, "R7 overrun clear", 32'(orer), 0);
    rx_send(9'h044, 0, 0, 1, "R7 after clear");
    rd_pulse();

    // 9 bits odd parity receive
    len = 2'd2; pe = 1; po = 1;
    rx_send(9'h155, 0, 0, 1, "R5 rx 9 bit");
    rd_pulse();

    repeat (10) @(negedge clk);
    chk(rxq.size() == 0, "R9 all rx chars seen", 32'(rxq.size()), 0);
    chk(txq.size() == 0, "R1 all tx frames seen", 32'(txq.size()), 0);
    finish_run();
  end
endmodule